// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is the control unit of a small accumulator machine, together with the datapath registers it steers and a single-port word memory. A two-bit phase register picks one of four phases. A per-phase step counter walks through timing steps. On every clock the pair (phase, step), plus the opcode held in the instruction register, is decoded into one group of register-transfer enables. Those enables cover the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator, along with the memory read and write strobes.

Three operations are executed:
- a memory-operand add into the accumulator;
- increment-and-skip-on-zero;
- a subroutine call that stores its return address in the target word and resumes one word later.

Any instruction may use one level of indirect addressing. A single external interrupt request can divert the machine after an instruction completes. On that path the return address is stored at a fixed save location, execution jumps to a fixed service address, and further interrupts are disabled until a re-enable pulse arrives.

While reset is held, a load port writes program and data words into the memory.

Top module: `icc_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, instruction, address and buffer registers and the step counter, selects the fetch phase (code 00) and enables interrupts. Phase codes are: fetch 00, indirect 01, execute 10, interrupt 11. Steps are numbered from 0.
- R2: Fetch takes three steps. Step 0 copies PC to the address register. Step 1 reads memory into the buffer and increments PC. Step 2 moves the buffer into IR. The instruction word is bit 15 = indirect flag, bits 14:12 = opcode, bits 11:0 = address.
- R3: If the fetched word has bit 15 set, the next phase is indirect. It takes three steps: address from IR[11:0], memory read into the buffer, then IR[11:0] is replaced by the buffer's low 12 bits. Execute then follows. Otherwise execute follows fetch directly.
- R4: Opcode 001 adds the memory word at the effective address to the accumulator. It takes three execute steps.
- R5: Opcode 010 takes four execute steps: read, increment the buffer, then write the buffer back to memory. In that last step, PC is incremented if the incremented value is zero.
- R6: Opcode 011 takes three execute steps. Step 0 loads the address from IR and the buffer from PC. Step 1 writes the buffer to memory and loads PC from IR[11:0]. Step 2 increments PC.
- R7: Interrupt entry takes three steps. Step 0 loads the buffer from PC. Step 1 loads the address register with SAVE_ADDR and PC with ISR_ADDR. Step 2 writes the buffer to memory and disables interrupts. Fetch follows.
- R8: After the last execute step, the next phase is interrupt only if the request is high and interrupts are enabled; otherwise it is fetch. A one-cycle enable pulse re-enables interrupts.
- R9: Any opcode other than 001, 010 and 011 spends one execute step with no transfer and then leaves the execute phase.
- R10: The step counter returns to 0 on every phase change. The read strobe is high exactly in the memory-read steps, the write strobe exactly in the memory-write steps, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interrupt request, level |
| ien_set_i | input | 1 | Pulse that re-enables interrupts |
| ld_we_i | input | 1 | Load-port write enable |
| ld_addr_i | input | 12 | Load-port word address |
| ld_data_i | input | 16 | Load-port write data |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| mar_o | output | 12 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| phase_o | output | 2 | Current phase code |
| step_o | output | 2 | Current step within the phase |
| ien_o | output | 1 | Interrupts enabled |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
The test program includes an increment that wraps to zero. A design that skipped on the wrong value, or tested before the increment, would execute the word it should have jumped over and leave a different accumulator. An indirect call and an indirect add are included because a design that failed to replace the address field would branch to, or read from, the pointer word itself. The interrupt request stays high long enough for a second entry to be attempted while interrupts are disabled: a design that ignored the enable would re-enter at once and overwrite the saved return address. An undefined opcode checks that a missing default decode neither stalls the step counter nor jumps.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INT   = 2'b11
  } phase_e;

  // one group of micro-operation enables for a single step
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_load;
    logic ir_addr_load;
    logic pc_inc;
    logic pc_ir;
    logic pc_isr;
    logic pc_skipz;
    logic ac_add;
    logic rd;
    logic wr;
    logic ien_clr;
  } ctrl_t;

endpackage

// File: rtl/icc_seq.sv
module icc_seq
  import icc_pkg::*;
#(
  parameter int OP_W   = 3,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req_i,
  input  logic              ien_set_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              ind_i,
  output ctrl_t             ctrl_o,
  output logic [1:0]        phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic              ien_o
);

  localparam logic [OP_W-1:0]   OP_ADD = OP_W'(1);
  localparam logic [OP_W-1:0]   OP_ISZ = OP_W'(2);
  localparam logic [OP_W-1:0]   OP_BSA = OP_W'(3);
  localparam logic [STEP_W-1:0] S0     = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1     = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2     = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3     = STEP_W'(3);

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q;
  logic              ien_q;
  logic              last;
  ctrl_t             c;

  always_comb begin
    c       = '0;
    last    = 1'b0;
    phase_d = PH_FETCH;
    case (phase_q)
      PH_FETCH: begin
        phase_d = ind_i ? PH_IND : PH_EXEC;
        case (step_q)
          S0:      c.mar_pc = 1'b1;
          S1:      begin c.mbr_mem = 1'b1; c.rd = 1'b1; c.pc_inc = 1'b1; end
          S2:      begin c.ir_load = 1'b1; last = 1'b1; end
          default: last = 1'b1;
        endcase
      end
      PH_IND: begin
        phase_d = PH_EXEC;
        case (step_q)
          S0:      c.mar_ir = 1'b1;
          S1:      begin c.mbr_mem = 1'b1; c.rd = 1'b1; end
          S2:      begin c.ir_addr_load = 1'b1; last = 1'b1; end
          default: last = 1'b1;
        endcase
      end
      PH_EXEC: begin
        phase_d = (irq_req_i && ien_q) ? PH_INT : PH_FETCH;
        case (op_i)
          OP_ADD: begin
            case (step_q)
              S0:      c.mar_ir = 1'b1;
              S1:      begin c.mbr_mem = 1'b1; c.rd = 1'b1; end
              default: begin c.ac_add = 1'b1; last = 1'b1; end
            endcase
          end
          OP_ISZ: begin
            case (step_q)
              S0:      c.mar_ir = 1'b1;
              S1:      begin c.mbr_mem = 1'b1; c.rd = 1'b1; end
              S2:      c.mbr_inc = 1'b1;
              S3:      begin c.wr = 1'b1; c.pc_skipz = 1'b1; last = 1'b1; end
              default: last = 1'b1;
            endcase
          end
          OP_BSA: begin
            case (step_q)
              S0:      begin c.mar_ir = 1'b1; c.mbr_pc = 1'b1; end
              S1:      begin c.pc_ir = 1'b1; c.wr = 1'b1; end
              default: begin c.pc_inc = 1'b1; last = 1'b1; end
            endcase
          end
          default: last = 1'b1;
        endcase
      end
      default: begin
        phase_d = PH_FETCH;
        case (step_q)
          S0:      c.mbr_pc = 1'b1;
          S1:      begin c.mar_save = 1'b1; c.pc_isr = 1'b1; end
          default: begin c.wr = 1'b1; c.ien_clr = 1'b1; last = 1'b1; end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
      ien_q   <= 1'b1;
    end else begin
      if (last) begin
        phase_q <= phase_d;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
      if (c.ien_clr)      ien_q <= 1'b0;
      else if (ien_set_i) ien_q <= 1'b1;
    end
  end

  assign ctrl_o  = c;
  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign ien_o   = ien_q;

endmodule

// File: rtl/icc_dp.sv
module icc_dp
  import icc_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o
);

  logic [ADDR_W-1:0] pc_q, mar_q, mar_d;
  logic [DATA_W-1:0] ac_q, ir_q, mbr_q;
  logic              mbr_zero;

  assign mbr_zero = (mbr_q == '0);

  always_comb begin
    mar_d = mar_q;
    if (ctrl_i.mar_pc)        mar_d = pc_q;
    else if (ctrl_i.mar_ir)   mar_d = ir_q[ADDR_W-1:0];
    else if (ctrl_i.mar_save) mar_d = SAVE_ADDR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ac_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
    end else begin
      mar_q <= mar_d;
      if (ctrl_i.mbr_mem)      mbr_q <= rdata_i;
      else if (ctrl_i.mbr_pc)  mbr_q <= DATA_W'(pc_q);
      else if (ctrl_i.mbr_inc) mbr_q <= mbr_q + 1'b1;
      if (ctrl_i.ir_load)           ir_q <= mbr_q;
      else if (ctrl_i.ir_addr_load) ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
      if (ctrl_i.pc_ir)       pc_q <= ir_q[ADDR_W-1:0];
      else if (ctrl_i.pc_isr) pc_q <= ISR_ADDR;
      else if (ctrl_i.pc_inc || (ctrl_i.pc_skipz && mbr_zero))
        pc_q <= pc_q + 1'b1;
      if (ctrl_i.ac_add) ac_q <= ac_q + mbr_q;
    end
  end

  assign raddr_o = mar_d;
  assign pc_o    = pc_q;
  assign ac_o    = ac_q;
  assign ir_o    = ir_q;
  assign mar_o   = mar_q;
  assign mbr_o   = mbr_q;

endmodule

// File: rtl/icc_ram.sv
module icc_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/icc_top.sv
module icc_top
  import icc_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'hFF0,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'hFF1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req_i,
  input  logic              ien_set_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [1:0]        phase_o,
  output logic [1:0]        step_o,
  output logic              ien_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);

  localparam int OP_W   = DATA_W - 1 - ADDR_W;
  localparam int STEP_W = 2;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  icc_seq #(.OP_W(OP_W), .STEP_W(STEP_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .irq_req_i (irq_req_i),
    .ien_set_i (ien_set_i),
    .op_i      (ir_o[DATA_W-2:ADDR_W]),
    .ind_i     (mbr_o[DATA_W-1]),
    .ctrl_o    (ctrl),
    .phase_o   (phase_o),
    .step_o    (step_o),
    .ien_o     (ien_o)
  );

  icc_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl_i  (ctrl),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .pc_o    (pc_o),
    .ac_o    (ac_o),
    .ir_o    (ir_o),
    .mar_o   (mar_o),
    .mbr_o   (mbr_o)
  );

  // load port owns the write port while reset is held
  assign ram_we    = ld_we_i | ctrl.wr;
  assign ram_waddr = ld_we_i ? ld_addr_i : mar_o;
  assign ram_wdata = ld_we_i ? ld_data_i : mbr_o;

  icc_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign mem_rd_o = ctrl.rd;
  assign mem_wr_o = ctrl.wr;

endmodule

// File: rtl/icc_chk.sv
module icc_chk #(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] ISR_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        phase_o,
  input logic [1:0]        step_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [DATA_W-1:0] mbr_o,
  input logic              ien_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o
);

  a_r2_fetch_pc_inc: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b00 && step_o == 2'd1) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  a_r3_ind_addr_swap: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b01 && step_o == 2'd2) |=>
      ir_o[ADDR_W-1:0] == $past(mbr_o[ADDR_W-1:0]));

  a_r7_int_vector: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b11 && step_o == 2'd1) |=> pc_o == ISR_ADDR);

  a_r8_masked_irq: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'b10 && !ien_o) |=> phase_o != 2'b11);

  a_r10_step_restart: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> step_o == 2'd0);

  a_r10_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

endmodule

bind icc_top icc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .phase_o  (phase_o),
  .step_o   (step_o),
  .pc_o     (pc_o),
  .ir_o     (ir_o),
  .mbr_o    (mbr_o),
  .ien_o    (ien_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o)
);

// File: tb/icc_top_tb.sv
`timescale 1ns/1ps
module icc_top_tb_top;

  localparam logic [11:0] SAVE = 12'hFF0;
  localparam logic [11:0] ISR  = 12'hFF1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic        ien_set = 1'b0;
  logic        ld_we = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [11:0] pc_o, mar_o;
  logic [15:0] ac_o, ir_o, mbr_o;
  logic [1:0]  phase_o, step_o;
  logic        ien_o, mem_rd_o, mem_wr_o;

  always #2.5 clk = ~clk;

  icc_top dut_i (
    .clk(clk), .rst(rst), .irq_req_i(irq_req), .ien_set_i(ien_set),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .pc_o(pc_o), .ac_o(ac_o), .ir_o(ir_o), .mar_o(mar_o), .mbr_o(mbr_o),
    .phase_o(phase_o), .step_o(step_o), .ien_o(ien_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mmem [4096];
  logic [1:0]  m_ph, m_st;
  logic [11:0] m_pc, m_mar;
  logic [15:0] m_ac, m_ir, m_mbr;
  logic        m_ien;

  function automatic logic [15:0] ins(input bit ind, input int op, input int adr);
    return {ind, 3'(op), 12'(adr)};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [1:0]  n_ph, n_st;
    logic [11:0] n_pc, n_mar, a;
    logic [15:0] n_ac, n_ir, n_mbr;
    logic        n_ien, last, clr;
    int op;
    if (rst) begin
      m_ph = 0; m_st = 0; m_pc = 0; m_ac = 0; m_ir = 0; m_mar = 0; m_mbr = 0; m_ien = 1;
      return;
    end
    n_ph = 0; n_st = m_st; n_pc = m_pc; n_mar = m_mar; n_ac = m_ac; n_ir = m_ir;
    n_mbr = m_mbr; n_ien = m_ien; last = 0; clr = 0;
    a = m_ir[11:0]; op = int'(m_ir[14:12]);
    case (m_ph)
      2'b00: begin
        if (m_st == 0) n_mar = m_pc;
        else if (m_st == 1) begin n_mbr = mmem[m_mar]; n_pc = m_pc + 12'd1; end
        else begin n_ir = m_mbr; last = 1; n_ph = m_mbr[15] ? 2'b01 : 2'b10; end
      end
      2'b01: begin
        n_ph = 2'b10;
        if (m_st == 0) n_mar = a;
        else if (m_st == 1) n_mbr = mmem[m_mar];
        else begin n_ir[11:0] = m_mbr[11:0]; last = 1; end
      end
      2'b10: begin
        n_ph = (irq_req && m_ien) ? 2'b11 : 2'b00;
        if (op == 1) begin
          if (m_st == 0) n_mar = a;
          else if (m_st == 1) n_mbr = mmem[m_mar];
          else begin n_ac = m_ac + m_mbr; last = 1; end
        end else if (op == 2) begin
          if (m_st == 0) n_mar = a;
          else if (m_st == 1) n_mbr = mmem[m_mar];
          else if (m_st == 2) n_mbr = m_mbr + 16'd1;
          else begin
            mmem[m_mar] = m_mbr;
            if (m_mbr == 0) n_pc = m_pc + 12'd1;
            last = 1;
          end
        end else if (op == 3) begin
          if (m_st == 0) begin n_mar = a; n_mbr = {4'b0, m_pc}; end
          else if (m_st == 1) begin n_pc = a; mmem[m_mar] = m_mbr; end
          else begin n_pc = m_pc + 12'd1; last = 1; end
        end else last = 1;
      end
      default: begin
        n_ph = 2'b00;
        if (m_st == 0) n_mbr = {4'b0, m_pc};
        else if (m_st == 1) begin n_mar = SAVE; n_pc = ISR; end
        else begin mmem[m_mar] = m_mbr; clr = 1; last = 1; end
      end
    endcase
    if (clr) n_ien = 0;
    else if (ien_set) n_ien = 1;
    if (last) n_st = 0; else begin n_st = m_st + 2'd1; n_ph = m_ph; end
    m_ph = n_ph; m_st = n_st; m_pc = n_pc; m_mar = n_mar; m_ac = n_ac;
    m_ir = n_ir; m_mbr = n_mbr; m_ien = n_ien;
  endtask

  function automatic string tag_of();
    int op;
    op = int'(m_ir[14:12]);
    case (m_ph)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b11: return "R7";
      default: return (op == 1) ? "R4" : (op == 2) ? "R5" : (op == 3) ? "R6" : "R9";
    endcase
  endfunction

  task automatic compare();
    bit erd, ewr;
    int op;
    string t;
    op = int'(m_ir[14:12]);
    t = tag_of();
    erd = (m_st == 1) && (m_ph == 2'b00 || m_ph == 2'b01 || (m_ph == 2'b10 && (op == 1 || op == 2)));
    ewr = (m_ph == 2'b10 && op == 2 && m_st == 3) || (m_ph == 2'b10 && op == 3 && m_st == 1) ||
          (m_ph == 2'b11 && m_st == 2);
    chk(t, "pc", pc_o, m_pc);
    chk(t, "ac", ac_o, m_ac);
    chk(t, "ir", ir_o, m_ir);
    chk(t, "mar", mar_o, m_mar);
    chk(t, "mbr", mbr_o, m_mbr);
    chk("R10", "phase", phase_o, m_ph);
    chk("R10", "step", step_o, m_st);
    chk("R8", "ien", ien_o, m_ien);
    chk("R10", "rd_strobe", mem_rd_o, erd);
    chk("R10", "wr_strobe", mem_wr_o, ewr);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ints_seen = 0;
    bit f2 = 0, f5 = 0, f302 = 0, wait_isr = 0;
    logic [1:0] prev_ph = 2'b00;
    for (int i = 0; i < 4096; i++) mmem[i] = 16'h0000;
    mmem[12'h000] = ins(0, 1, 12'h100);
    mmem[12'h001] = ins(1, 1, 12'h101);
    mmem[12'h002] = ins(0, 2, 12'h103);
    mmem[12'h003] = ins(0, 1, 12'h100);
    mmem[12'h004] = ins(0, 2, 12'h104);
    mmem[12'h005] = ins(0, 3, 12'h200);
    mmem[12'h201] = 16'h7000;
    mmem[12'h202] = ins(0, 1, 12'h104);
    mmem[12'h203] = ins(1, 3, 12'h105);
    mmem[12'h301] = ins(0, 1, 12'h300);
    mmem[12'hFF1] = ins(0, 1, 12'hFF0);
    mmem[12'h100] = 16'd5;
    mmem[12'h101] = 16'h0102;
    mmem[12'h102] = 16'd7;
    mmem[12'h103] = 16'hFFFF;
    mmem[12'h104] = 16'd1;
    mmem[12'h105] = 16'h0300;
    model_edge();
    for (int i = 0; i < 4096; i++) begin
      @(posedge clk); #1;
      ld_we = 1'b1; ld_addr = 12'(i); ld_data = mmem[i];
    end
    @(posedge clk); #1;
    ld_we = 1'b0;
    @(posedge clk); #1;
    model_edge();
    // R1: reset state
    chk("R1", "pc", pc_o, 0);
    chk("R1", "ac", ac_o, 0);
    chk("R1", "phase", phase_o, 0);
    chk("R1", "step", step_o, 0);
    chk("R1", "ien", ien_o, 1);
    rst = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(posedge clk); #1;
      model_edge();
      compare();
      if (phase_o == 2'b11 && prev_ph != 2'b11) begin ints_seen++; wait_isr = 1; end
      if (wait_isr && phase_o == 2'b00 && prev_ph == 2'b11) begin
        chk("R7", "pc after entry", pc_o, ISR);
        chk("R7", "ien after entry", ien_o, 0);
        wait_isr = 0;
      end
      if (phase_o == 2'b00 && step_o == 0) begin
        if (!f2 && pc_o == 12'h002) begin f2 = 1; chk("R3", "ac after indirect add", ac_o, 12); end
        if (!f5 && pc_o == 12'h005) begin f5 = 1; chk("R5", "ac after skip", ac_o, 12); end
        if (!f302 && pc_o == 12'h302) begin f302 = 1; chk("R6", "ac after calls", ac_o, 16'h0212); end
      end
      prev_ph = phase_o;
      irq_req = (cyc >= 150 && cyc < 260);
      ien_set = (cyc == 230);
    end
    chk("R5", "first pass reached 0x005", f5, 1);
    chk("R6", "first pass reached 0x302", f302, 1);
    chk("R8", "interrupt entries", ints_seen, 2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule